// File: doc/BRIEF.md
# Flash Line Write Buffer with Forced Commit

This block sits between the core's program-write path and a flash array that is programmed one 32-byte line at a time. Software enables programming, picks a write width of 1, 2, 4 or 8 bytes, and issues data writes with addresses. The block merges those writes into one buffered line tagged with its 32-byte aligned address. When every byte of the line has been written, the line goes to the array on its own. A partially written line goes only when software raises the force-commit input. Bytes that were never written are handed over with their mask bit clear and their data at the erased value 0xFF.

The array is represented by a stub that holds the line for a fixed number of cycles and then reports completion. Status outputs show whether the buffer holds data, whether a line is queued or being programmed, and whether an operation has completed. Two sticky error flags report a write to a different line and a write that is not aligned to its own width.

Top module: `pgm_wbuf`

## Requirements
- R1: A line is LINE_BYTES (32) bytes, aligned on a 32-byte boundary. wr_addr[4:0] selects the starting byte. Write byte i goes to line byte wr_addr[4:0]+i, and prog_addr is the line address with its low 5 bits zero. Line byte j is prog_data[8j+7:8j] and prog_mask[j].
- R2: psize selects the write width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, 3 for 8 bytes. The bytes are taken from the low end of wr_data, least significant byte first.
- R3: A write presented while pg_en is low is ignored. It changes neither the buffer nor any flag.
- R4: When all 32 mask bits are set, the line starts programming on the next clock edge with force_wr low, and prog_mask is all ones.
- R5: While force_wr is high and the buffer is not empty, the partial line is committed. Unwritten bytes have prog_mask 0 and prog_data 0xFF.
- R6: wbne is high exactly while the buffer holds at least one byte. qw is high while a line is programming, or while a full or forced line waits for the array.
- R7: When a line finishes programming, eop is set on the same edge that prog_busy falls. eop stays set until clr_flags is high.
- R8: An aligned, enabled write to a different line while wbne is high sets inc_err. The buffer is emptied and the write is dropped.
- R9: An enabled write with wr_addr not a multiple of its width sets strb_err. The write is dropped and the buffer is unchanged.
- R10: prog_busy stays high for exactly PROG_CYCLES cycles per line. prog_addr, prog_data and prog_mask stay stable throughout.
- R11: A later write to a byte already in the buffer replaces that byte's data.
- R12: clr_flags clears eop, inc_err and strb_err. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_en | input | 1 | Programming enable; writes are accepted only while high |
| psize | input | 2 | Write width code |
| force_wr | input | 1 | Commit a partially filled line |
| clr_flags | input | 1 | Clear eop and the error flags |
| wr_valid | input | 1 | Write strobe, one per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data, low bytes used |
| prog_busy | output | 1 | A line is being programmed into the array |
| prog_addr | output | ADDR_W | Aligned address of the line in the array |
| prog_data | output | 256 | Line data handed to the array |
| prog_mask | output | 32 | Valid-byte mask of that line |
| qw | output | 1 | Line queued or being programmed |
| wbne | output | 1 | Write buffer not empty |
| eop | output | 1 | End-of-operation flag (sticky) |
| inc_err | output | 1 | Write to another line while buffer held data (sticky) |
| strb_err | output | 1 | Write not aligned to its width (sticky) |

## Verification
The bench fills whole lines with random mixes of naturally aligned widths to confirm the automatic commit. A design that miscounted filled bytes would either never start programming or start one write early with holes in the mask. Forced partial lines with overlapping writes expose bytes that were placed at the wrong lane, not left at 0xFF, or not replaced by a later write. Directed cases write to a second line and send a misaligned word between valid bytes. A design that merged the stray write, or kept the old buffer, would show the wrong mask or leave wbne set. The bench also counts prog_busy cycles and checks eop persistence, which catches an off-by-one delay and a flag that clears itself.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        PSZ_B8  = 2'd0,
        PSZ_B16 = 2'd1,
        PSZ_B32 = 2'd2,
        PSZ_B64 = 2'd3
    } psz_e;
endpackage

// File: rtl/wbuf_lane_merge.sv
module wbuf_lane_merge #(
    parameter int LINE_BYTES = 32,
    parameter int DATA_BYTES = 8
) (
    input  logic [$clog2(LINE_BYTES)-1:0] off,
    input  logic [1:0]                    psize,
    input  logic [DATA_BYTES*8-1:0]       wr_data,
    output logic [LINE_BYTES-1:0]         byte_en,
    output logic [LINE_BYTES*8-1:0]       bit_en,
    output logic [LINE_BYTES*8-1:0]       lane_data,
    output logic                          misalign
);
    import wbuf_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SEL_W = $clog2(DATA_BYTES);

    logic [OFF_W:0] nb;

    always_comb begin
        unique case (psz_e'(psize))
            PSZ_B8:  nb = (OFF_W+1)'(1);
            PSZ_B16: nb = (OFF_W+1)'(2);
            PSZ_B32: nb = (OFF_W+1)'(4);
            default: nb = (OFF_W+1)'(8);
        endcase
        misalign = |(off & (nb[OFF_W-1:0] - OFF_W'(1)));
    end

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] KIDX = OFF_W'(k);
        logic [OFF_W-1:0] rel;
        logic             hit;
        always_comb begin
            rel = KIDX - off;
            hit = (KIDX >= off) && ({1'b0, rel} < nb);
        end
        assign byte_en[k]          = hit;
        assign bit_en[k*8 +: 8]    = {8{hit}};
        assign lane_data[k*8 +: 8] = wr_data[{rel[SEL_W-1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/wbuf_array_stub.sv
module wbuf_array_stub #(
    parameter int TAG_W       = 27,
    parameter int LINE_BYTES  = 32,
    parameter int PROG_CYCLES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [TAG_W-1:0]        tag_in,
    input  logic [LINE_BYTES*8-1:0] data_in,
    input  logic [LINE_BYTES-1:0]   mask_in,
    output logic                    busy,
    output logic                    done,
    output logic [TAG_W-1:0]        tag_out,
    output logic [LINE_BYTES*8-1:0] data_out,
    output logic [LINE_BYTES-1:0]   mask_out
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic                    busy;
        logic [CNT_W-1:0]        cnt;
        logic [TAG_W-1:0]        tag;
        logic [LINE_BYTES*8-1:0] data;
        logic [LINE_BYTES-1:0]   mask;
    } stub_st_t;

    stub_st_t st_d, st_q;
    logic     fin;

    always_comb begin
        st_d = st_q;
        fin  = st_q.busy && (st_q.cnt == CNT_W'(1));
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (fin) st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PROG_CYCLES);
            st_d.tag  = tag_in;
            st_d.data = data_in;
            st_d.mask = mask_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.data <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = fin;
    assign tag_out  = st_q.tag;
    assign data_out = st_q.data;
    assign mask_out = st_q.mask;
endmodule

// File: rtl/pgm_wbuf.sv
module pgm_wbuf #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int DATA_BYTES  = 8,
    parameter int PROG_CYCLES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pg_en,
    input  logic [1:0]              psize,
    input  logic                    force_wr,
    input  logic                    clr_flags,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_BYTES*8-1:0] wr_data,
    output logic                    prog_busy,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic [LINE_BYTES*8-1:0] prog_data,
    output logic [LINE_BYTES-1:0]   prog_mask,
    output logic                    qw,
    output logic                    wbne,
    output logic                    eop,
    output logic                    inc_err,
    output logic                    strb_err
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        logic [LINE_W-1:0]     data;
        logic [LINE_BYTES-1:0] mask;
        logic [TAG_W-1:0]      tag;
        logic                  eop;
        logic                  inc_err;
        logic                  strb_err;
    } wb_st_t;

    wb_st_t st_d, st_q;

    logic [LINE_BYTES-1:0] m_byte_en;
    logic [LINE_W-1:0]     m_bit_en;
    logic [LINE_W-1:0]     m_lane;
    logic                  m_misalign;
    logic                  stub_busy, stub_done;
    logic [TAG_W-1:0]      stub_tag;

    logic                  buf_any, buf_full, handoff, wr_try;
    logic [TAG_W-1:0]      wr_tag;
    logic [LINE_W-1:0]     base_data;
    logic [LINE_BYTES-1:0] base_mask;

    wbuf_lane_merge #(
        .LINE_BYTES(LINE_BYTES),
        .DATA_BYTES(DATA_BYTES)
    ) merge_i (
        .off      (wr_addr[OFF_W-1:0]),
        .psize    (psize),
        .wr_data  (wr_data),
        .byte_en  (m_byte_en),
        .bit_en   (m_bit_en),
        .lane_data(m_lane),
        .misalign (m_misalign)
    );

    wbuf_array_stub #(
        .TAG_W      (TAG_W),
        .LINE_BYTES (LINE_BYTES),
        .PROG_CYCLES(PROG_CYCLES)
    ) stub_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (handoff),
        .tag_in  (st_q.tag),
        .data_in (st_q.data),
        .mask_in (st_q.mask),
        .busy    (stub_busy),
        .done    (stub_done),
        .tag_out (stub_tag),
        .data_out(prog_data),
        .mask_out(prog_mask)
    );

    always_comb begin
        buf_any  = |st_q.mask;
        buf_full = &st_q.mask;
        handoff  = buf_any && (buf_full || force_wr) && !stub_busy;
        wr_try   = wr_valid && pg_en;
        wr_tag   = wr_addr[ADDR_W-1:OFF_W];

        st_d = st_q;

        if (handoff) begin
            st_d.data = '1;
            st_d.mask = '0;
        end

        base_data = handoff ? '1 : st_q.data;
        base_mask = handoff ? '0 : st_q.mask;

        if (clr_flags) begin
            st_d.eop      = 1'b0;
            st_d.inc_err  = 1'b0;
            st_d.strb_err = 1'b0;
        end

        if (stub_done) st_d.eop = 1'b1;

        if (wr_try) begin
            if (m_misalign) begin
                st_d.strb_err = 1'b1;
            end else if (!handoff && buf_any && (wr_tag != st_q.tag)) begin
                st_d.inc_err = 1'b1;
                st_d.data    = '1;
                st_d.mask    = '0;
            end else begin
                st_d.data = (base_data & ~m_bit_en) | (m_lane & m_bit_en);
                st_d.mask = base_mask | m_byte_en;
                st_d.tag  = wr_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.data <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_busy = stub_busy;
    assign prog_addr = {stub_tag, {OFF_W{1'b0}}};
    assign qw        = stub_busy || (buf_any && (buf_full || force_wr));
    assign wbne      = buf_any;
    assign eop       = st_q.eop;
    assign inc_err   = st_q.inc_err;
    assign strb_err  = st_q.strb_err;
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pg_en,
    input logic [1:0]              psize,
    input logic                    wr_valid,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic                    clr_flags,
    input logic                    prog_busy,
    input logic [LINE_BYTES*8-1:0] prog_data,
    input logic [LINE_BYTES-1:0]   prog_mask,
    input logic                    qw,
    input logic                    wbne,
    input logic                    eop,
    input logic                    strb_err
);
    p_qw_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> qw);

    p_eop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> eop);

    p_hold_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy)) |-> ($stable(prog_data) && $stable(prog_mask)));

    p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_en && wr_valid && psize == 2'd3 && wr_addr[2:0] != 3'd0) |=> strb_err);

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_en && !wbne) |=> !wbne);

    p_start_from_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(wbne));

    p_eop_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eop && !clr_flags) |=> eop);
endmodule

bind pgm_wbuf wbuf_checker #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_en    (pg_en),
    .psize    (psize),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .clr_flags(clr_flags),
    .prog_busy(prog_busy),
    .prog_data(prog_data),
    .prog_mask(prog_mask),
    .qw       (qw),
    .wbne     (wbne),
    .eop      (eop),
    .strb_err (strb_err)
);

// File: tb/pgm_wbuf_tb_top.sv
`timescale 1ns/1ps
module pgm_wbuf_tb_top;
    localparam int AW = 32;
    localparam int PC = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pg_en = 1'b0, force_wr = 1'b0, clr_flags = 1'b0, wr_valid = 1'b0;
    logic [1:0]   psize = 2'd0;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0]  wr_data = '0;
    logic         prog_busy, qw, wbne, eop, inc_err, strb_err;
    logic [AW-1:0] prog_addr;
    logic [255:0] prog_data;
    logic [31:0]  prog_mask;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    logic [255:0] exp_data;
    logic [31:0]  exp_mask;
    logic [26:0]  exp_line;

    always #4 clk = ~clk;

    pgm_wbuf #(.ADDR_W(AW), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .psize(psize), .force_wr(force_wr),
        .clr_flags(clr_flags), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_busy(prog_busy), .prog_addr(prog_addr), .prog_data(prog_data),
        .prog_mask(prog_mask), .qw(qw), .wbne(wbne), .eop(eop), .inc_err(inc_err),
        .strb_err(strb_err)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] s);
        return 1 << s;
    endfunction

    task automatic mdl_clear();
        exp_data = '1;
        exp_mask = '0;
    endtask

    task automatic mdl_put(input logic [AW-1:0] a, input logic [63:0] d, input logic [1:0] s);
        for (int i = 0; i < nbytes(s); i++) begin
            int b;
            b = int'(a[4:0]) + i;
            exp_data[b*8 +: 8] = d[i*8 +: 8];
            exp_mask[b] = 1'b1;
        end
        exp_line = a[31:5];
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [1:0] s);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; psize = s;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    // waits for a line to start, compares it, counts busy cycles and checks eop
    task automatic chk_line(input string req);
        int n;
        int guard;
        guard = 0;
        while (!prog_busy && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk({req, " line start"}, 256'(prog_busy), 256'(1));
        chk({req, " R1 addr"}, 256'(prog_addr), 256'({exp_line, 5'd0}));
        chk({req, " R5 data"}, prog_data, exp_data);
        chk({req, " R5 mask"}, 256'(prog_mask), 256'(exp_mask));
        chk({req, " R6 qw busy"}, 256'(qw), 256'(1));
        n = 0;
        while (prog_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R10 busy cycles", 256'(n), 256'(PC));
        chk("R7 eop set", 256'(eop), 256'(1));
        repeat (2) @(negedge clk);
        chk("R7 eop sticky", 256'(eop), 256'(1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        logic [1:0] s;
        int off;
        void'($urandom(32'd20240415));
        mdl_clear();
        exp_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset wbne", 256'(wbne), 256'(0));
        chk("reset qw", 256'(qw), 256'(0));
        chk("reset flags", 256'({eop, inc_err, strb_err, prog_busy}), 256'(0));

        // R3: disabled write ignored
        wr(32'h0800_0040, 64'h11, 2'd0);
        @(negedge clk);
        chk("R3 disabled write wbne", 256'(wbne), 256'(0));
        chk("R3 disabled write flags", 256'({inc_err, strb_err}), 256'(0));
        pg_en = 1'b1;

        // R1/R2/R5/R6: single byte then force
        mdl_clear();
        wr(32'h0800_0065, 64'hA5, 2'd0); mdl_put(32'h0800_0065, 64'hA5, 2'd0);
        chk("R6 wbne after write", 256'(wbne), 256'(1));
        chk("R6 qw idle partial", 256'(qw), 256'(0));
        @(negedge clk); force_wr = 1'b1;
        chk_line("R5 single byte");
        chk("R6 wbne after commit", 256'(wbne), 256'(0));
        chk("R6 qw after commit", 256'(qw), 256'(0));
        force_wr = 1'b0;
        pulse_clr();
        chk("R12 eop cleared", 256'(eop), 256'(0));

        // R11 overwrite, R2 half and dword placement
        mdl_clear();
        wr(32'h0800_0108, 64'h0102_0304_0506_0708, 2'd3); mdl_put(32'h0800_0108, 64'h0102_0304_0506_0708, 2'd3);
        wr(32'h0800_010A, 64'hBEEF, 2'd1);                 mdl_put(32'h0800_010A, 64'hBEEF, 2'd1);
        wr(32'h0800_011C, 64'hCAFE_F00D, 2'd2);            mdl_put(32'h0800_011C, 64'hCAFE_F00D, 2'd2);
        @(negedge clk); force_wr = 1'b1;
        chk_line("R11 overwrite");
        force_wr = 1'b0;
        pulse_clr();

        // R9 misaligned word dropped
        mdl_clear();
        wr(32'h0800_0200, 64'h3C, 2'd0); mdl_put(32'h0800_0200, 64'h3C, 2'd0);
        wr(32'h0800_0202, 64'hDEAD_BEEF, 2'd2);
        chk("R9 strb_err", 256'(strb_err), 256'(1));
        chk("R9 buffer kept", 256'(wbne), 256'(1));
        @(negedge clk); force_wr = 1'b1;
        chk_line("R9 dropped write");
        force_wr = 1'b0;
        pulse_clr();
        chk("R12 strb cleared", 256'(strb_err), 256'(0));

        // R8 incoherent write
        wr(32'h0800_0300, 64'h77, 2'd0);
        wr(32'h0800_0320, 64'h88, 2'd0);
        chk("R8 inc_err", 256'(inc_err), 256'(1));
        chk("R8 buffer discarded", 256'(wbne), 256'(0));
        @(negedge clk); force_wr = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 nothing programmed", 256'(prog_busy), 256'(0));
        force_wr = 1'b0;
        pulse_clr();
        chk("R12 inc cleared", 256'(inc_err), 256'(0));

        // R4: random full lines, auto commit
        for (int t = 0; t < 12; t++) begin
            base = {$urandom, 5'd0} & 32'h000F_FFE0;
            base = base | 32'h0800_0000;
            mdl_clear();
            off = 0;
            while (off < 32) begin
                s = 2'($urandom % 4);
                while ((off % nbytes(s)) != 0) s = s - 2'd1;
                wr(base + AW'(off), {$urandom, $urandom}, s);
                mdl_put(base + AW'(off), {wr_data}, s);
                off += nbytes(s);
                if (off < 32) chk("R4 no early start", 256'(prog_busy), 256'(0));
            end
            chk_line("R4 auto full");
            chk("R4 full mask", 256'(exp_mask), 256'(32'hFFFF_FFFF));
            pulse_clr();
        end

        // R5/R11: random partial forced lines
        for (int t = 0; t < 16; t++) begin
            int k;
            base = ({$urandom, 5'd0} & 32'h000F_FFE0) | 32'h0800_0000;
            mdl_clear();
            k = 1 + ($urandom % 4);
            for (int j = 0; j < k; j++) begin
                logic [AW-1:0] a;
                s = 2'($urandom % 4);
                a = base + AW'((($urandom % 32) / nbytes(s)) * nbytes(s));
                wr(a, {$urandom, $urandom}, s);
                mdl_put(a, wr_data, s);
            end
            @(negedge clk); force_wr = 1'b1;
            chk_line("R5 random partial");
            force_wr = 1'b0;
            pulse_clr();
        end

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule